// File: doc/BRIEF.md
# Daily Latching Valve Timer

This block drives one irrigation valve for a single timed window per day. A start event clears an internal prescaled binary counter and switches the valve on. The counter then advances, one count per prescaler period, until a chosen counter bit goes high. At that point the counter freezes and the valve stays off until the next start event. A start event is either a rising power-good level, such as a solar supply coming up at dawn, or a press of the manual restart button.

Two 2-bit selects configure the window. The stop select picks the counter bit that ends the window, and so sets its length. In pulsed drive mode, the pulse select picks a lower counter bit that the valve follows during the window, which gives on/off watering in place of a steady flow. The valve drive is active low. A status output tells indicator lamps whether the day's window has finished.

Top module: `valve_window_timer`

## Requirements
- R1: While rst_n is low, valve_n is 1 (valve off) and window_done is 0.
- R2: After reset, nothing starts while pwr_good stays low. When pwr_good rises, the counter starts from zero and valve_n goes low on the third rising clock edge after pwr_good is first sampled high.
- R3: With drive_mode = 0 (steady), valve_n stays low for exactly PRESCALE * 2^(STOP_BASE + stop_sel) consecutive cycles and then goes high once.
- R4: stop_sel value k selects counter bit STOP_BASE + k as the stop bit, for k = 0 to 3.
- R5: Once the window ends, the counter is frozen and valve_n stays 1 and window_done stays 1 until the next start event, even if drive_mode, stop_sel or pulse_sel change.
- R6: With drive_mode = 1 (pulsed), during the window valve_n equals counter bit PULSE_BASE + pulse_sel. Over the window it is low for half the steady duration and rises 2^(STOP_BASE + stop_sel - PULSE_BASE - pulse_sel - 1) times.
- R7: A rising edge on manual_start while pwr_good is high restarts the window from zero at any time, including in the middle of a running window.
- R8: A fall of pwr_good forces valve_n to 1 and window_done to 0 within 3 cycles, and holds the counter cleared. manual_start is ignored while pwr_good is low.
- R9: window_done is 0 while a window runs and becomes 1 one cycle after the valve turns off at the window's end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Asynchronous supply-good level; its rise starts a window and its low level holds the block idle |
| manual_start | input | 1 | Asynchronous restart button; a rising edge starts a new window |
| drive_mode | input | 1 | 0 = steady drive, 1 = pulsed drive |
| stop_sel | input | SEL_W | Stop bit choice; sets the window length |
| pulse_sel | input | SEL_W | Pulse bit choice for pulsed mode |
| valve_n | output | 1 | Active-low valve drive |
| window_done | output | 1 | 1 once the day's window has finished |

## Verification
Each start request passes through a two-flop synchroniser and an edge register, so the valve turns on in the third cycle after the request is seen. Every stimulus task therefore returns at the falling edge that follows that third rising edge, and the measurement begins on exactly the first on-cycle. From there, each falling edge samples the valve until window_done goes high, one cycle after the valve turns off. The on-cycle and rising-edge counts are compared with the exact values from R3 and R6. Checks for power loss and for the frozen state are made at least 3 cycles after the stimulus, which covers the fixed synchroniser latency.

// File: rtl/vwt_pkg.sv
package vwt_pkg;
   typedef enum logic {
      DRIVE_STEADY = 1'b0,
      DRIVE_PULSED = 1'b1
   } drive_mode_e;
endpackage

// File: rtl/vwt_sync_edge.sv
module vwt_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("vwt_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level = chain_q[STAGES-1];
   assign rise  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/vwt_prescaler.sv
module vwt_prescaler #(
   parameter int unsigned PRESCALE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

   logic [PW-1:0] div_q;

   generate
      if (PRESCALE < 1) begin : g_bad
         $error("vwt_prescaler: PRESCALE must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (clr) begin
         div_q <= '0;
      end else if (en) begin
         div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
      end
   end

   assign tick = en & ~clr & (div_q == LAST);
endmodule

// File: rtl/vwt_tap_counter.sv
module vwt_tap_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/valve_window_timer.sv
module valve_window_timer
   import vwt_pkg::*;
#(
   parameter int unsigned PRESCALE    = 4,
   parameter int unsigned STOP_BASE   = 4,
   parameter int unsigned PULSE_BASE  = 0,
   parameter int unsigned SEL_W       = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_good,
   input  logic             manual_start,
   input  logic             drive_mode,
   input  logic [SEL_W-1:0] stop_sel,
   input  logic [SEL_W-1:0] pulse_sel,
   output logic             valve_n,
   output logic             window_done
);
   localparam int unsigned NTAP  = 1 << SEL_W;
   localparam int unsigned CNT_W = STOP_BASE + NTAP;

   generate
      if (PULSE_BASE + NTAP > STOP_BASE) begin : g_bad_taps
         $error("valve_window_timer: every pulse bit must lie below every stop bit");
      end
   endgenerate

   logic             pg_ok, pg_rise, btn_rise;
   logic             start_evt, hold_clr, cnt_clr;
   logic             running_q, done_q;
   logic             stop_hit, pulse_bit, advance, tick, valve_on;
   logic [CNT_W-1:0] cnt_q;
   logic [NTAP-1:0]  stop_taps, pulse_taps;
   drive_mode_e      mode_e;

   vwt_sync_edge #(.STAGES(SYNC_STAGES)) u_pg_sync (
      .clk(clk), .rst_n(rst_n), .din(pwr_good), .level(pg_ok), .rise(pg_rise)
   );

   logic btn_level_unused;
   vwt_sync_edge #(.STAGES(SYNC_STAGES)) u_btn_sync (
      .clk(clk), .rst_n(rst_n), .din(manual_start), .level(btn_level_unused), .rise(btn_rise)
   );

   assign start_evt = pg_rise | (btn_rise & pg_ok);
   assign hold_clr  = ~pg_ok;
   assign cnt_clr   = start_evt | hold_clr;

   // tap vectors: stop bits above pulse bits
   generate
      for (genvar g = 0; g < NTAP; g++) begin : g_taps
         assign stop_taps[g]  = cnt_q[STOP_BASE + g];
         assign pulse_taps[g] = cnt_q[PULSE_BASE + g];
      end
   endgenerate

   assign stop_hit  = stop_taps[stop_sel];
   assign pulse_bit = pulse_taps[pulse_sel];
   assign advance   = running_q & ~stop_hit;

   vwt_prescaler #(.PRESCALE(PRESCALE)) u_presc (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(advance), .tick(tick)
   );

   vwt_tap_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick), .cnt_q(cnt_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         done_q    <= 1'b0;
      end else if (hold_clr) begin
         running_q <= 1'b0;
         done_q    <= 1'b0;
      end else if (start_evt) begin
         running_q <= 1'b1;
         done_q    <= 1'b0;
      end else if (running_q && stop_hit) begin
         running_q <= 1'b0;
         done_q    <= 1'b1;
      end
   end

   assign mode_e      = drive_mode_e'(drive_mode);
   assign valve_on    = advance & ((mode_e == DRIVE_STEADY) | ~pulse_bit);
   assign valve_n     = ~valve_on;
   assign window_done = done_q;
endmodule

// File: rtl/vwt_checker.sv
module vwt_checker #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valve_n,
   input logic             window_done,
   input logic             start_evt,
   input logic             pg_ok,
   input logic [CNT_W-1:0] cnt_q
);
   // R5: a finished window never drives the valve
   p_done_valve_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      window_done |-> valve_n);

   // R5: finished state is sticky and the counter frozen while power stays and no start arrives
   p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (window_done && pg_ok && !start_evt) |=> window_done);

   p_frozen_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (window_done && pg_ok && !start_evt) |=> $stable(cnt_q));

   // R2 / R7: a start event clears the count and the done flag
   p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> (cnt_q == '0 && !window_done));

   // R8: power low clears the counter and shuts the valve
   p_power_low_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pg_ok |=> (cnt_q == '0 && valve_n && !window_done));

   // R3: the counter only ever holds or steps by one
   p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_ok && !start_evt) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

bind valve_window_timer vwt_checker #(.CNT_W(CNT_W)) u_vwt_checker (
   .clk(clk), .rst_n(rst_n), .valve_n(valve_n), .window_done(window_done),
   .start_evt(start_evt), .pg_ok(pg_ok), .cnt_q(cnt_q)
);

// File: tb/valve_window_timer_bench.sv
module valve_window_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_good = 1'b0;
   logic       manual_start = 1'b0;
   logic       drive_mode = 1'b0;
   logic [1:0] stop_sel = 2'd0;
   logic [1:0] pulse_sel = 2'd0;
   logic       valve_n, window_done;

   int unsigned checks = 0;
   int unsigned errors = 0;
   int unsigned cyc = 0;

   always #10 clk = ~clk;

   valve_window_timer u_valve_window_timer (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .manual_start(manual_start),
      .drive_mode(drive_mode), .stop_sel(stop_sel), .pulse_sel(pulse_sel),
      .valve_n(valve_n), .window_done(window_done)
   );

   // defaults: PRESCALE 4, stop bits 4..7, pulse bits 0..3
   typedef struct packed {
      logic        mode;
      logic [1:0]  ssel;
      logic [1:0]  psel;
      int unsigned on_cyc;
      int unsigned rises;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b0, 2'd0, 2'd0,  64, 1},
      '{1'b0, 2'd2, 2'd0, 256, 1},
      '{1'b1, 2'd0, 2'd0,  32, 8},
      '{1'b1, 2'd1, 2'd2,  64, 4},
      '{1'b1, 2'd3, 2'd3, 256, 8},
      '{1'b0, 2'd1, 2'd1, 128, 1}
   };

   task automatic chk(input string req, input int unsigned act, input int unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic press();
      @(negedge clk) manual_start = 1'b1;
      repeat (3) @(negedge clk);
      manual_start = 1'b0;
   endtask

   task automatic power_up();
      @(negedge clk) pwr_good = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic measure(output int unsigned on_cnt, output int unsigned rise_cnt);
      logic prev = 1'b0;
      int unsigned n = 0;
      on_cnt = 0;
      rise_cnt = 0;
      while (!window_done && n < 4000) begin
         if (!valve_n) on_cnt++;
         if (!prev && valve_n) rise_cnt++;
         prev = valve_n;
         n++;
         @(negedge clk);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned on_c, rs_c;
      repeat (5) @(negedge clk);
      chk("R1 valve_n", valve_n, 1);
      chk("R1 done", window_done, 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R2 idle valve_n", valve_n, 1);
      chk("R2 idle done", window_done, 0);

      // R2: power-up start, steady, stop bit 4
      power_up();
      chk("R2 first on-cycle", valve_n, 0);
      measure(on_c, rs_c);
      chk("R2 window length", on_c, 64);

      // vector table walk via button restarts
      foreach (VECS[i]) begin
         drive_mode = VECS[i].mode;
         stop_sel   = VECS[i].ssel;
         pulse_sel  = VECS[i].psel;
         press();
         chk("R9 running", window_done, 0);
         measure(on_c, rs_c);
         chk(VECS[i].mode ? "R6 on cycles" : "R4 on cycles", on_c, VECS[i].on_cyc);
         chk(VECS[i].mode ? "R6 rises" : "R3 rises", rs_c, VECS[i].rises);
         chk("R9 done", window_done, 1);
         repeat (20) @(negedge clk);
         chk("R5 off after end", valve_n, 1);
         chk("R5 done held", window_done, 1);
      end

      // R5: select changes after the end have no effect
      drive_mode = 1'b1;
      stop_sel = 2'd0;
      pulse_sel = 2'd0;
      repeat (20) @(negedge clk);
      chk("R5 sel change valve_n", valve_n, 1);
      chk("R5 sel change done", window_done, 1);

      // R7: mid-window restart starts from zero
      drive_mode = 1'b0;
      stop_sel = 2'd3;
      press();
      repeat (100) @(negedge clk);
      chk("R7 mid valve_n", valve_n, 0);
      chk("R9 mid done", window_done, 0);
      press();
      measure(on_c, rs_c);
      chk("R7 restarted length", on_c, 512);

      // R8: power loss
      press();
      repeat (20) @(negedge clk);
      pwr_good = 1'b0;
      repeat (4) @(negedge clk);
      chk("R8 valve off", valve_n, 1);
      chk("R8 done low", window_done, 0);
      press();
      repeat (10) @(negedge clk);
      chk("R8 button ignored valve_n", valve_n, 1);
      chk("R8 button ignored done", window_done, 0);
      power_up();
      measure(on_c, rs_c);
      chk("R8 fresh window after power", on_c, 512);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule